// File: doc/BRIEF.md
# Floating-point exception trap arbiter

When a floating-point instruction completes, this block takes the eight exception flags that the instruction raised. It compares them with a software-written trap-enable byte and picks at most one trap vector by fixed priority. The instruction's flags are also folded into a sticky five-bit record of IEEE-style accrued exceptions. The eight flags give seven trap classes. The two inexact flags (rounding inexact and conversion inexact) share one vector. An overflow whose own trap is disabled falls back to the inexact trap when rounding-inexact trapping is enabled.

All ports are plain strobes. The completion strobe has no ready signal, and the block accepts one status byte on every cycle, back-to-back if needed. The trap output is a one-cycle pulse with no back-pressure. The consumer must capture it in the cycle it appears. The enable byte and the accrued byte are loaded through simple write strobes.

Top module: `fpx_trap_arbiter`

## Requirements
- R1: After reset, the accrued byte reads 0, no trap is pending, the vector reads 0 and every enable bit is 0. A status byte taken right after reset therefore raises no trap.
- R2: A trap request is a single-cycle pulse in the cycle after the completion strobe, with the vector valid in that same cycle. Back-to-back strobes give back-to-back pulses. While no trap is raised the vector reads 0.
- R3: Status and enable bits, from bit 7 down to bit 0, are bad-branch-condition, signalling-NaN, operand-error, overflow, underflow, divide-by-zero, rounding-inexact and conversion-inexact. An enabled flag on its own gives vector 0, 1, 2, 3, 4 or 5 in that order. Vector 7 never appears.
- R4: When several enabled classes occur together, the lowest vector number wins.
- R5: Either inexact flag, when enabled, gives the shared vector 6.
- R6: If overflow is set, the overflow enable (bit 4) is clear and the rounding-inexact enable (bit 1) is set, the inexact vector 6 is taken, unless a higher-priority class applies.
- R7: Flags whose enable bits are clear raise no trap, except through R6.
- R8: Accrued bit 7 (invalid) is set by any of status bits 7..5. Accrued bit 6 is set by overflow. Accrued bit 4 is set by divide-by-zero.
- R9: Accrued bit 5 (underflow) is set only when underflow and rounding-inexact are both set in the same status byte. The underflow trap uses only the underflow flag and its enable.
- R10: Accrued bit 3 (inexact) is set by either inexact flag or by overflow.
- R11: Accrued bits stay set until they are cleared or written. Bits 2..0 always read 0.
- R12: A clear wins over a write and over a status fold in the same cycle. A write loads bits 7..3 of the write data, and a status fold in the same cycle is ORed on top.
- R13: An enable write takes effect from the next cycle. A status byte arriving in the cycle of the write is judged against the old enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| done_vld | input | 1 | Instruction-completion strobe |
| done_exc | input | 8 | Exception flags of the completing instruction |
| en_we | input | 1 | Trap-enable write strobe |
| en_wdata | input | 8 | New trap-enable byte |
| acc_clr | input | 1 | Clear the accrued byte |
| acc_we | input | 1 | Write the accrued byte |
| acc_wdata | input | 8 | Accrued write data (bits 7..3 used) |
| acc_q | output | 8 | Accrued exception byte |
| trap_req | output | 1 | Trap request pulse |
| trap_vec | output | 3 | Trap vector code |

## Verification
The hardest case to reach from the ports is the overflow fallback. It needs overflow set, the overflow enable clear and the rounding-inexact enable set. At the same moment, no enabled higher-priority class may be present, and an enable write may be landing in the same cycle. The stimulus reaches this with directed sequences that program the enable byte first and then issue the exact flag patterns. Random phases then re-program the enables often, including in the same cycle as a completion, so that the fallback and the old-versus-new enable timing come up many times.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int EXC_W = 8;
  localparam int NCLS  = 7;
  localparam int VEC_W = $clog2(NCLS + 1);
  localparam int ACC_W = 5;
  localparam int ACC_LO = EXC_W - ACC_W;

  // status / enable bit positions (priority order follows these)
  localparam int S_BSUN  = 7;
  localparam int S_SNAN  = 6;
  localparam int S_OPERR = 5;
  localparam int S_OVFL  = 4;
  localparam int S_UNFL  = 3;
  localparam int S_DZ    = 2;
  localparam int S_INEX2 = 1;
  localparam int S_INEX1 = 0;

  // accrued bit positions
  localparam int A_IOP  = 7;
  localparam int A_OVFL = 6;
  localparam int A_UNFL = 5;
  localparam int A_DZ   = 4;
  localparam int A_INEX = 3;

  localparam logic [EXC_W-1:0] ACC_MASK = EXC_W'(((1 << ACC_W) - 1) << ACC_LO);

  localparam int V_INEX = NCLS - 1;
endpackage

// File: rtl/fpx_class_req.sv
module fpx_class_req
  import fpx_pkg::*;
(
  input  logic [EXC_W-1:0] exc,
  input  logic [EXC_W-1:0] en,
  output logic [NCLS-1:0]  req
);
  // classes 0..NCLS-2 map one-to-one onto status bits, highest bit first
  for (genvar k = 0; k < NCLS - 1; k++) begin : g_direct
    assign req[k] = exc[EXC_W-1-k] & en[EXC_W-1-k];
  end

  // shared inexact class, including the overflow fallback
  logic inex_own;
  logic ovf_fallback;
  assign inex_own     = (exc[S_INEX2] & en[S_INEX2]) | (exc[S_INEX1] & en[S_INEX1]);
  assign ovf_fallback = exc[S_OVFL] & ~en[S_OVFL] & en[S_INEX2];
  assign req[V_INEX]  = inex_own | ovf_fallback;
endmodule

// File: rtl/fpx_prio_pick.sv
module fpx_prio_pick #(
  parameter int N = 7
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any_req
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar k = 0; k < N; k++) begin : g_chain
    assign gnt[k]    = req[k] & ~seen[k];
    assign seen[k+1] = seen[k] | req[k];
  end

  assign any_req = seen[N];
endmodule

// File: rtl/fpx_accrue.sv
module fpx_accrue
  import fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [EXC_W-1:0] exc,
  input  logic             clr,
  input  logic             we,
  input  logic [EXC_W-1:0] wdata,
  output logic [EXC_W-1:0] acc_q
);
  logic [EXC_W-1:0] fold;
  logic [EXC_W-1:0] base;

  always_comb begin
    fold         = '0;
    fold[A_IOP]  = exc[S_BSUN] | exc[S_SNAN] | exc[S_OPERR];
    fold[A_OVFL] = exc[S_OVFL];
    fold[A_UNFL] = exc[S_UNFL] & exc[S_INEX2];
    fold[A_DZ]   = exc[S_DZ];
    fold[A_INEX] = exc[S_INEX2] | exc[S_INEX1] | exc[S_OVFL];
    base         = we ? (wdata & ACC_MASK) : acc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else          acc_q <= base | (upd ? fold : '0);
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0)); // R12

  AST_ACC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !we) |=> ((acc_q & $past(acc_q)) == $past(acc_q))); // R11

  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q[ACC_LO-1:0] == '0); // R11

  AST_UNFL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_q[A_UNFL]) |-> ($past(we) || ($past(upd) && $past(exc[S_UNFL]) && $past(exc[S_INEX2])))); // R9
endmodule

// File: rtl/fpx_trap_arbiter.sv
module fpx_trap_arbiter
  import fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_vld,
  input  logic [EXC_W-1:0] done_exc,
  input  logic             en_we,
  input  logic [EXC_W-1:0] en_wdata,
  input  logic             acc_clr,
  input  logic             acc_we,
  input  logic [EXC_W-1:0] acc_wdata,
  output logic [EXC_W-1:0] acc_q,
  output logic             trap_req,
  output logic [VEC_W-1:0] trap_vec
);
  logic [EXC_W-1:0] en_q;
  logic [NCLS-1:0]  req;
  logic [NCLS-1:0]  gnt;
  logic             any_req;
  logic [VEC_W-1:0] code;

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_wdata;
  end

  fpx_class_req u_req (
    .exc (done_exc),
    .en  (en_q),
    .req (req)
  );

  fpx_prio_pick #(.N(NCLS)) u_pick (
    .req     (req),
    .gnt     (gnt),
    .any_req (any_req)
  );

  always_comb begin
    code = '0;
    for (int k = 0; k < NCLS; k++) begin
      if (gnt[k]) code = code | VEC_W'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_req <= 1'b0;
      trap_vec <= '0;
    end else begin
      trap_req <= done_vld & any_req;
      trap_vec <= (done_vld & any_req) ? code : '0;
    end
  end

  fpx_accrue u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (done_vld),
    .exc   (done_exc),
    .clr   (acc_clr),
    .we    (acc_we),
    .wdata (acc_wdata),
    .acc_q (acc_q)
  );

  AST_TRAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(done_vld)); // R2

  AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> (trap_vec == '0)); // R2

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_vec < VEC_W'(NCLS))); // R3

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R4

  AST_OVF_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld && done_exc[S_OVFL] && !en_q[S_OVFL] && en_q[S_INEX2] &&
     ((done_exc[S_BSUN:S_OPERR] & en_q[S_BSUN:S_OPERR]) == '0) &&
     ((done_exc[S_UNFL:S_DZ] & en_q[S_UNFL:S_DZ]) == '0))
    |=> (trap_req && trap_vec == VEC_W'(V_INEX))); // R6
endmodule

// File: tb/fpx_trap_arbiter_tb_top.sv
`timescale 1ns/1ps
module fpx_trap_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       done_vld = 1'b0;
  logic [7:0] done_exc = '0;
  logic       en_we = 1'b0;
  logic [7:0] en_wdata = '0;
  logic       acc_clr = 1'b0;
  logic       acc_we = 1'b0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] acc_q;
  logic       trap_req;
  logic [2:0] trap_vec;

  int total = 0;
  int bad = 0;
  bit fin = 1'b0;
  logic [7:0] en_m = '0;
  logic [7:0] acc_m = '0;

  always #4 clk = ~clk;

  fpx_trap_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .done_vld(done_vld), .done_exc(done_exc),
    .en_we(en_we), .en_wdata(en_wdata), .acc_clr(acc_clr), .acc_we(acc_we),
    .acc_wdata(acc_wdata), .acc_q(acc_q), .trap_req(trap_req), .trap_vec(trap_vec)
  );

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // expected trap from the priority list in the requirements
  function automatic void ref_trap(input logic [7:0] s, input logic [7:0] e,
                                   output bit hit, output int vec);
    hit = 1'b0; vec = 0;
    for (int c = 0; c < 7; c++) begin
      bit cond;
      if (c < 6) cond = s[7-c] && e[7-c];
      else cond = (s[1] && e[1]) || (s[0] && e[0]) || (s[4] && !e[4] && e[1]);
      if (cond && !hit) begin hit = 1'b1; vec = c; end
    end
  endfunction

  function automatic logic [7:0] ref_fold(input logic [7:0] s);
    logic [7:0] r = '0;
    if (s[7] || s[6] || s[5]) r[7] = 1'b1;
    if (s[4]) r[6] = 1'b1;
    if (s[3] && s[1]) r[5] = 1'b1;
    if (s[2]) r[4] = 1'b1;
    if (s[1] || s[0] || s[4]) r[3] = 1'b1;
    return r;
  endfunction

  task automatic step(bit dv, logic [7:0] ex, bit ew, logic [7:0] ed,
                      bit ac, bit aw, logic [7:0] ad, string tag);
    bit hit; int vec; logic [7:0] acc_n;
    done_vld = dv; done_exc = ex; en_we = ew; en_wdata = ed;
    acc_clr = ac; acc_we = aw; acc_wdata = ad;
    ref_trap(ex, en_m, hit, vec);
    hit = hit && dv;
    if (ac) acc_n = '0;
    else acc_n = (aw ? (ad & 8'hF8) : acc_m) | (dv ? ref_fold(ex) : 8'h00);
    @(posedge clk);
    @(negedge clk);
    if (ew) en_m = ed;
    acc_m = acc_n;
    done_vld = 1'b0; en_we = 1'b0; acc_clr = 1'b0; acc_we = 1'b0;
    chk(tag, "trap_req", int'(trap_req), int'(hit));
    chk(tag, "trap_vec", int'(trap_vec), hit ? vec : 0);
    chk(tag, "acc_q", int'(acc_q), int'(acc_m));
  endtask

  task automatic set_en(logic [7:0] v, string tag);
    step(0, 8'h00, 1, v, 0, 0, 8'h00, tag);
  endtask

  task automatic trap_case(logic [7:0] ex, string tag);
    step(1, ex, 0, 8'h00, 1, 0, 8'h00, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!fin) begin
      total++; bad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "acc_q", int'(acc_q), 0);
    chk("R1", "trap_req", int'(trap_req), 0);
    chk("R1", "trap_vec", int'(trap_vec), 0);
    step(1, 8'hFF, 0, 8'h00, 0, 0, 8'h00, "R1"); // enables cleared: no trap
    step(0, 8'h00, 0, 8'h00, 1, 0, 8'h00, "R12");

    // R3 singles, R5 inexact pair
    set_en(8'hFF, "R3");
    for (int c = 0; c < 6; c++) trap_case(8'h80 >> c, "R3");
    trap_case(8'h02, "R5");
    trap_case(8'h01, "R5");
    // R4 priority, including the legal combined cases
    trap_case(8'hFF, "R4");
    trap_case(8'h41, "R4");
    trap_case(8'h22, "R4");
    trap_case(8'h21, "R4");
    trap_case(8'h13, "R4");
    trap_case(8'h0B, "R4");
    trap_case(8'h03, "R4");
    trap_case(8'h0C, "R4");
    // R2 back-to-back pulses
    step(1, 8'h40, 0, 8'h00, 0, 0, 8'h00, "R2");
    step(1, 8'h04, 0, 8'h00, 0, 0, 8'h00, "R2");
    step(0, 8'h00, 0, 8'h00, 0, 0, 8'h00, "R2");
    // R6 overflow fallback
    set_en(8'h02, "R6");
    trap_case(8'h10, "R6");
    set_en(8'h01, "R6");
    trap_case(8'h10, "R6");
    set_en(8'h12, "R6");
    trap_case(8'h10, "R6");
    set_en(8'h0A, "R6");
    trap_case(8'h18, "R6");
    // R7 disabled flags ignored
    set_en(8'h80, "R7");
    trap_case(8'h7F, "R7");
    set_en(8'h00, "R7");
    trap_case(8'hEF, "R7");
    // R9 underflow gating, trap from underflow alone
    step(0, 8'h00, 0, 8'h00, 1, 0, 8'h00, "R9");
    set_en(8'h08, "R9");
    step(1, 8'h08, 0, 8'h00, 0, 0, 8'h00, "R9");
    step(1, 8'h0A, 0, 8'h00, 0, 0, 8'h00, "R9");
    // R8 and R10 accrued folds
    step(0, 8'h00, 0, 8'h00, 1, 0, 8'h00, "R8");
    step(1, 8'h20, 0, 8'h00, 0, 0, 8'h00, "R8");
    step(1, 8'h04, 0, 8'h00, 0, 0, 8'h00, "R8");
    step(0, 8'h00, 0, 8'h00, 1, 0, 8'h00, "R10");
    step(1, 8'h10, 0, 8'h00, 0, 0, 8'h00, "R10");
    step(0, 8'h00, 0, 8'h00, 1, 0, 8'h00, "R10");
    step(1, 8'h01, 0, 8'h00, 0, 0, 8'h00, "R10");
    // R11 sticky and low bits
    step(0, 8'h00, 0, 8'h00, 0, 0, 8'h00, "R11");
    step(1, 8'h00, 0, 8'h00, 0, 0, 8'h00, "R11");
    step(0, 8'h00, 0, 8'h00, 0, 1, 8'hFF, "R11");
    // R12 precedence
    step(0, 8'h00, 0, 8'h00, 1, 1, 8'hFF, "R12");
    step(1, 8'hFF, 0, 8'h00, 1, 0, 8'h00, "R12");
    step(1, 8'h04, 0, 8'h00, 0, 1, 8'h80, "R12");
    // R13 enable write timing
    set_en(8'h00, "R13");
    step(1, 8'h80, 1, 8'hFF, 0, 0, 8'h00, "R13");
    step(1, 8'h80, 1, 8'h00, 0, 0, 8'h00, "R13");
    step(1, 8'h80, 0, 8'h00, 0, 0, 8'h00, "R13");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] ex;
      ex = 8'($urandom());
      if ($urandom_range(0, 1) == 1) ex = ex & 8'($urandom()) & 8'($urandom());
      step($urandom_range(0, 9) < 7, ex,
           $urandom_range(0, 9) == 0, 8'($urandom()),
           $urandom_range(0, 19) == 0, $urandom_range(0, 19) == 0, 8'($urandom()),
           "R4");
    end

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule